// File: doc/BRIEF.md
# Hysteretic Drive Level Selector

This block chooses one of eight steady-state drive-current levels for a power transistor from a measured load current. Each time the PWM output goes low, it waits a programmable blanking time so that the turn-off transient can settle. It then accumulates a power-of-two number of converter samples and takes their mean.

The mean is compared against two threshold tables. The "raise" table moves the level up and the "drop" table moves it down. Both tables are selected by the present level and by a temperature row. Because the drop threshold of a level sits below the raise threshold of the level beneath it, the level does not chatter. The level moves by at most one step per switching period. A saturated converter reading, or a mean below a fault code (a disconnected sensor supply reads near zero, while a true zero current reads well above it), forces the highest level at once.

The chosen level is presented as a 3-bit enable vector for three binary-weighted parallel resistor paths. A fourth path is always on outside the block. The vector only changes while the PWM is low, so each on-interval runs at a single level.

Top module: `drive_level_sel`

## Requirements
- R1: After a synchronous active-low reset, `sw_en` is 3'b111 (the highest level, 7). Both tables reset to raise = 4095 and drop = 0, the fault code resets to 248, the blanking length to 2 and the temperature boundaries to 255.
- R2: When the window mean is strictly greater than the raise threshold for the present level and temperature row, the level rises by one. The level saturates at 7.
- R3: When the window mean is strictly less than the drop threshold for the present level and temperature row, the level falls by one. The level saturates at 0.
- R4: When the mean lies between the drop and raise thresholds (both inclusive), the level is held.
- R5: A window begins on each PWM falling edge. The first `blank` valid samples are ignored (blank is the programmed blanking length plus one, counted in cycles from the falling-edge cycle). After that, the first 4 valid samples taken while PWM is low are averaged as sum/4, truncated. Samples while PWM is high are ignored, and each off-interval yields at most one decision.
- R6: `sw_en` takes the newly decided level on the first clock edge at which `pwm_on` is low. It never changes on an edge at which `pwm_on` is high.
- R7: The temperature row equals the number of temperature boundaries that `temp_code` strictly exceeds. With two rows, row 1 is used when `temp_code` is greater than boundary 0.
- R8: A window mean strictly below the fault code forces level 7. A mean equal to the fault code is treated as a normal measurement.
- R9: Any sample of 4095 inside a window forces level 7 for that decision.
- R10: Configuration is written in one cycle with `cfg_we` high. `cfg_tbl` = 0 writes the raise table at [`cfg_row`][`cfg_idx`], and 1 writes the drop table at the same position. A value of 2 writes temperature boundary `cfg_idx` from `cfg_data[7:0]`. A value of 3 writes the fault code when `cfg_idx` = 0, and the blanking length from `cfg_data[5:0]` when `cfg_idx` = 1.
- R11: `sw_en` is the level written in binary. Bit i enables the path whose weight is 2^i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_on | input | 1 | PWM state, high during the on-interval |
| adc_valid | input | 1 | Strobe marking a new converter sample |
| adc_data | input | 12 | Converter sample code |
| temp_code | input | 8 | Temperature measurement code |
| cfg_we | input | 1 | Configuration write enable |
| cfg_tbl | input | 2 | Configuration target select |
| cfg_row | input | 1 | Temperature row of a table write |
| cfg_idx | input | 3 | Level index or entry index of a write |
| cfg_data | input | 12 | Configuration value |
| sw_en | output | 3 | Enables for the switched resistor paths |

## Verification
Two events can fall in the same cycle. A window can finish its averaging on the last cycle of an off-interval, so that the new decision is stored just as PWM rises. The bench provokes this by raising `pwm_on` one cycle after the fourth sample. It then checks that `sw_en` keeps the old level for the whole on-interval and takes the forced level only after PWM falls again. Sampling and blanking are also overlapped with full-scale junk samples, both during the on-interval and inside the blanking window. Any leak of these samples would show up as a jump to level 7.

// File: rtl/drv_pkg.sv
// Shared definitions of the drive level selector.
// Assumes: nothing beyond IEEE 1800-2017.
package drv_pkg;
    // Targets of the configuration write port
    typedef enum logic [1:0] {
        CFG_RAISE = 2'd0,
        CFG_DROP  = 2'd1,
        CFG_TEMP  = 2'd2,
        CFG_MISC  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/drv_sample_avg.sv
// Blanking and averaging of converter samples after each PWM falling edge.
// Assumes AVG_LOG2 >= 1. One window per off-interval; samples while the PWM
// is high or still in blanking are dropped.
module drv_sample_avg #(
    parameter int ADC_W    = 12,
    parameter int AVG_LOG2 = 2,
    parameter int BLANK_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwm_on,
    input  logic               adc_valid,
    input  logic [ADC_W-1:0]   adc_data,
    input  logic [BLANK_W-1:0] blank_len,
    output logic               avg_valid,
    output logic [ADC_W-1:0]   avg_data,
    output logic               avg_sat
);
    localparam int ACC_W = ADC_W + AVG_LOG2;
    localparam logic [AVG_LOG2-1:0] LAST = '1;
    localparam logic [ADC_W-1:0]    FULL = '1;

    logic               pwm_d;
    logic [BLANK_W-1:0] blank_cnt;
    logic [AVG_LOG2-1:0] n_cnt;
    logic [ACC_W-1:0]   acc;
    logic               sat_seen;
    logic               done;
    logic [ACC_W-1:0]   sum_next;
    logic               is_full;

    assign sum_next = acc + ACC_W'(adc_data);
    assign is_full  = (adc_data == FULL);

    // Window sequencing: blank, accumulate, publish one mean
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_d     <= 1'b0;
            blank_cnt <= '0;
            n_cnt     <= '0;
            acc       <= '0;
            sat_seen  <= 1'b0;
            done      <= 1'b1;
            avg_valid <= 1'b0;
            avg_data  <= '0;
            avg_sat   <= 1'b0;
        end else begin
            pwm_d     <= pwm_on;
            avg_valid <= 1'b0;
            if (pwm_d && !pwm_on) begin
                blank_cnt <= blank_len;
                n_cnt     <= '0;
                acc       <= '0;
                sat_seen  <= 1'b0;
                done      <= 1'b0;
            end else if (!pwm_on && !done) begin
                if (blank_cnt != '0) begin
                    blank_cnt <= blank_cnt - 1'b1;
                end else if (adc_valid) begin
                    if (n_cnt == LAST) begin
                        avg_valid <= 1'b1;
                        avg_data  <= sum_next[ACC_W-1:AVG_LOG2];
                        avg_sat   <= sat_seen | is_full;
                        done      <= 1'b1;
                    end else begin
                        acc      <= sum_next;
                        sat_seen <= sat_seen | is_full;
                        n_cnt    <= n_cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R5: no mean is published from a cycle in which PWM was high
    assert_no_sample_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwm_on) |-> !avg_valid);
    // R5: a window ends after its mean, never two means back to back
    assert_one_mean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |=> !avg_valid);
endmodule

// File: rtl/drv_thresh_tbl.sv
// Threshold storage and lookup: raise/drop tables per temperature row and
// level, temperature boundaries, fault code and blanking length.
// Assumes TEMP_ROWS >= 2; writes take effect on the next cycle.
module drv_thresh_tbl
    import drv_pkg::*;
#(
    parameter int ADC_W     = 12,
    parameter int LVL_W     = 3,
    parameter int TEMP_ROWS = 2,
    parameter int TEMP_W    = 8,
    parameter int BLANK_W   = 6,
    parameter int FAULT_RST = 248,
    parameter int BLANK_RST = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_tbl,
    input  logic [$clog2(TEMP_ROWS)-1:0] cfg_row,
    input  logic [LVL_W-1:0]             cfg_idx,
    input  logic [ADC_W-1:0]             cfg_data,
    input  logic [TEMP_W-1:0]            temp_code,
    input  logic [LVL_W-1:0]             level,
    output logic [ADC_W-1:0]             raise_thr,
    output logic [ADC_W-1:0]             drop_thr,
    output logic [ADC_W-1:0]             fault_thr,
    output logic [BLANK_W-1:0]           blank_len
);
    localparam int NLVL  = 1 << LVL_W;
    localparam int ROW_W = $clog2(TEMP_ROWS);
    localparam int NBND  = TEMP_ROWS - 1;

    logic [ADC_W-1:0]  raise_q [TEMP_ROWS][NLVL];
    logic [ADC_W-1:0]  drop_q  [TEMP_ROWS][NLVL];
    logic [TEMP_W-1:0] bnd_q   [NBND];
    logic [ROW_W-1:0]  row;

    // Configuration registers and their write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < TEMP_ROWS; r++) begin
                for (int l = 0; l < NLVL; l++) begin
                    raise_q[r][l] <= '1;
                    drop_q[r][l]  <= '0;
                end
            end
            for (int b = 0; b < NBND; b++) bnd_q[b] <= '1;
            fault_thr <= ADC_W'(FAULT_RST);
            blank_len <= BLANK_W'(BLANK_RST);
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_tbl))
                CFG_RAISE: raise_q[cfg_row][cfg_idx] <= cfg_data;
                CFG_DROP:  drop_q[cfg_row][cfg_idx]  <= cfg_data;
                CFG_TEMP: begin
                    for (int b = 0; b < NBND; b++)
                        if (int'(cfg_idx) == b) bnd_q[b] <= cfg_data[TEMP_W-1:0];
                end
                default: begin
                    if (cfg_idx == '0) fault_thr <= cfg_data;
                    else if (cfg_idx == LVL_W'(1)) blank_len <= cfg_data[BLANK_W-1:0];
                end
            endcase
        end
    end

    // Temperature row: count of boundaries strictly exceeded
    always_comb begin
        row = '0;
        for (int b = 0; b < NBND; b++)
            if (temp_code > bnd_q[b]) row = row + 1'b1;
    end

    assign raise_thr = raise_q[row][level];
    assign drop_thr  = drop_q[row][level];

    // R10: a fault-code write is visible on the next cycle
    assert_fault_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_tbl == 2'd3 && cfg_idx == '0) |=> fault_thr == $past(cfg_data));
endmodule

// File: rtl/drv_level_step.sv
// Level decision and deferred application to the switch enables.
// Assumes one mean strobe per off-interval; the enables only load while
// the PWM is low.
module drv_level_step #(
    parameter int ADC_W = 12,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_on,
    input  logic             avg_valid,
    input  logic [ADC_W-1:0] avg_data,
    input  logic             avg_sat,
    input  logic [ADC_W-1:0] raise_thr,
    input  logic [ADC_W-1:0] drop_thr,
    input  logic [ADC_W-1:0] fault_thr,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] sw_en
);
    localparam logic [LVL_W-1:0] MAXL = '1;

    logic [LVL_W-1:0] nxt;
    logic             forced;

    assign forced = avg_sat || (avg_data < fault_thr);

    // Next level: fail safe, else one hysteretic step
    always_comb begin
        nxt = level;
        if (forced)                   nxt = MAXL;
        else if (avg_data > raise_thr) nxt = (level == MAXL) ? level : level + 1'b1;
        else if (avg_data < drop_thr)  nxt = (level == '0) ? level : level - 1'b1;
    end

    // Decision register, updated once per window
    always_ff @(posedge clk) begin
        if (!rst_n)         level <= MAXL;
        else if (avg_valid) level <= nxt;
    end

    // Applied enables, loaded only outside the on-interval
    always_ff @(posedge clk) begin
        if (!rst_n)       sw_en <= MAXL;
        else if (!pwm_on) sw_en <= level;
    end

    // R2/R3: a normal measurement moves the level by one step at most
    assert_one_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_valid && !avg_sat && avg_data >= fault_thr) |=>
        (level == $past(level) || level == $past(level) + 1'b1 || level + 1'b1 == $past(level)));
    // R8: a mean below the fault code forces the top level
    assert_fault_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_valid && avg_data < fault_thr) |=> level == MAXL);
    // R9: a full-scale sample forces the top level
    assert_sat_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_valid && avg_sat) |=> level == MAXL);
    // R6: enables are frozen across an edge with the PWM high
    assert_hold_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_on |=> $stable(sw_en));
endmodule

// File: rtl/drive_level_sel.sv
// Top of the hysteretic drive level selector: averaging, threshold tables
// and level stepping. Assumes a free-running clock much faster than the PWM
// and a synchronous active-low reset.
module drive_level_sel #(
    parameter int ADC_W     = 12,
    parameter int LVL_W     = 3,
    parameter int TEMP_ROWS = 2,
    parameter int TEMP_W    = 8,
    parameter int AVG_LOG2  = 2,
    parameter int BLANK_W   = 6,
    parameter int FAULT_RST = 248,
    parameter int BLANK_RST = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pwm_on,
    input  logic                         adc_valid,
    input  logic [ADC_W-1:0]             adc_data,
    input  logic [TEMP_W-1:0]            temp_code,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_tbl,
    input  logic [$clog2(TEMP_ROWS)-1:0] cfg_row,
    input  logic [LVL_W-1:0]             cfg_idx,
    input  logic [ADC_W-1:0]             cfg_data,
    output logic [LVL_W-1:0]             sw_en
);
    logic               avg_valid;
    logic [ADC_W-1:0]   avg_data;
    logic               avg_sat;
    logic [ADC_W-1:0]   raise_thr;
    logic [ADC_W-1:0]   drop_thr;
    logic [ADC_W-1:0]   fault_thr;
    logic [BLANK_W-1:0] blank_len;
    logic [LVL_W-1:0]   level;

    drv_sample_avg #(.ADC_W(ADC_W), .AVG_LOG2(AVG_LOG2), .BLANK_W(BLANK_W)) u_avg (
        .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on),
        .adc_valid(adc_valid), .adc_data(adc_data), .blank_len(blank_len),
        .avg_valid(avg_valid), .avg_data(avg_data), .avg_sat(avg_sat)
    );

    drv_thresh_tbl #(
        .ADC_W(ADC_W), .LVL_W(LVL_W), .TEMP_ROWS(TEMP_ROWS), .TEMP_W(TEMP_W),
        .BLANK_W(BLANK_W), .FAULT_RST(FAULT_RST), .BLANK_RST(BLANK_RST)
    ) u_tbl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
        .cfg_row(cfg_row), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .temp_code(temp_code), .level(level),
        .raise_thr(raise_thr), .drop_thr(drop_thr),
        .fault_thr(fault_thr), .blank_len(blank_len)
    );

    drv_level_step #(.ADC_W(ADC_W), .LVL_W(LVL_W)) u_step (
        .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on),
        .avg_valid(avg_valid), .avg_data(avg_data), .avg_sat(avg_sat),
        .raise_thr(raise_thr), .drop_thr(drop_thr), .fault_thr(fault_thr),
        .level(level), .sw_en(sw_en)
    );
endmodule

// File: tb/tb_drive_level_sel.sv
// Self-checking bench: directed corner cases plus seeded random windows,
// compared against a bench-side level model.
module tb_drive_level_sel;
    localparam int BLANK = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_on = 1'b1;
    logic        adc_valid = 1'b0;
    logic [11:0] adc_data = '0;
    logic [7:0]  temp_code = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_tbl = '0;
    logic [0:0]  cfg_row = '0;
    logic [2:0]  cfg_idx = '0;
    logic [11:0] cfg_data = '0;
    logic [2:0]  sw_en;

    int n_chk = 0;
    int n_bad = 0;
    int m_lvl = 7;
    int up_t [2][8];
    int dn_t [2][8];
    bit finished = 0;

    always #5 clk = ~clk;

    drive_level_sel dut (
        .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on), .adc_valid(adc_valid),
        .adc_data(adc_data), .temp_code(temp_code), .cfg_we(cfg_we),
        .cfg_tbl(cfg_tbl), .cfg_row(cfg_row), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .sw_en(sw_en)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: sw_en=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected next level from R2, R3, R4, R8, R9 (fault code 248)
    function automatic int next_lvl(int lvl, int avg, bit sat, int row);
        if (sat || avg < 248) return 7;
        if (avg > up_t[row][lvl]) return (lvl == 7) ? 7 : lvl + 1;
        if (avg < dn_t[row][lvl]) return (lvl == 0) ? 0 : lvl - 1;
        return lvl;
    endfunction

    task automatic cfg_write(input int tbl, input int row, input int idx, input int val);
        cfg_we = 1'b1; cfg_tbl = 2'(tbl); cfg_row = 1'(row);
        cfg_idx = 3'(idx); cfg_data = 12'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one on-interval, blanking, four samples, then check (R5, R6)
    task automatic period(input int a, input int b, input int c, input int d,
                          input bit junk, input bit coincide, input string tag);
        int avg;
        bit sat;
        int old;
        pwm_on = 1'b1;
        adc_valid = junk; adc_data = 12'hFFF;
        repeat (3) @(negedge clk);
        pwm_on = 1'b0;
        for (int k = 0; k <= BLANK; k++) begin
            adc_valid = junk; adc_data = 12'hFFF;
            @(negedge clk);
        end
        adc_valid = 1'b1;
        adc_data = 12'(a); @(negedge clk);
        adc_data = 12'(b); @(negedge clk);
        adc_data = 12'(c); @(negedge clk);
        adc_data = 12'(d); @(negedge clk);
        adc_valid = 1'b0;
        avg = (a + b + c + d) / 4;
        sat = (a == 4095) || (b == 4095) || (c == 4095) || (d == 4095);
        old = m_lvl;
        m_lvl = next_lvl(m_lvl, avg, sat, (temp_code > 8'd100) ? 1 : 0);
        if (coincide) begin
            pwm_on = 1'b1;
            repeat (4) begin
                @(negedge clk);
                check(int'(sw_en), old, {tag, " R6 held during on"});
            end
            pwm_on = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(int'(sw_en), m_lvl, tag);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        for (int l = 0; l < 8; l++) begin
            up_t[0][l] = 400 + l * 400;
            up_t[1][l] = 300 + l * 300;
        end
        for (int l = 0; l < 8; l++) begin
            dn_t[0][l] = (l == 0) ? 0 : up_t[0][l-1] * 9 / 10;
            dn_t[1][l] = (l == 0) ? 0 : up_t[1][l-1] * 9 / 10;
        end
        repeat (3) @(negedge clk);
        check(int'(sw_en), 7, "R1 reset level");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(sw_en), 7, "R1 R11 after reset");

        // R10: program tables, boundary and blanking
        for (int r = 0; r < 2; r++)
            for (int l = 0; l < 8; l++) begin
                cfg_write(0, r, l, up_t[r][l]);
                cfg_write(1, r, l, dn_t[r][l]);
            end
        cfg_write(2, 0, 0, 100);
        cfg_write(3, 0, 1, BLANK);

        // R3: step down to 0 one level per window, then saturate
        for (int i = 0; i < 8; i++) period(260, 260, 260, 260, 0, 0, "R3 step down");
        period(260, 260, 260, 260, 0, 0, "R3 floor at 0");
        // R4: inside the hysteresis band
        period(300, 310, 290, 300, 0, 0, "R4 hold");
        // R8: mean equal to fault code is normal
        period(248, 248, 248, 248, 0, 0, "R8 mean at fault code");
        // R2: step up each window and saturate at 7
        for (int i = 0; i < 8; i++) period(4000, 4000, 4000, 4000, 0, 0, "R2 R11 step up");
        for (int i = 0; i < 8; i++) period(260, 260, 260, 260, 0, 0, "R3 return to 0");
        // R9: one full-scale sample forces top level
        period(500, 500, 4095, 500, 0, 0, "R9 saturated sample");
        for (int i = 0; i < 8; i++) period(260, 260, 260, 260, 0, 0, "R3 return to 0");
        // R8: disconnected sensor
        period(100, 120, 90, 110, 0, 0, "R8 fault forces max");
        for (int i = 0; i < 8; i++) period(260, 260, 260, 260, 0, 0, "R3 return to 0");
        // R5: junk full-scale samples during on-interval and blanking
        period(300, 300, 300, 300, 1, 0, "R5 junk ignored");
        // R5: truncating average (sum 1603 -> 400 holds at level 0)
        period(400, 401, 401, 401, 0, 0, "R5 truncated mean");
        // R7: hot row, 350 exceeds row-1 raise of 300
        temp_code = 8'd150;
        period(350, 350, 350, 350, 0, 0, "R7 hot row step up");
        temp_code = 8'd100;
        period(350, 350, 350, 350, 0, 0, "R7 boundary uses cool row");
        for (int i = 0; i < 3; i++) period(260, 260, 260, 260, 0, 0, "R3 return to 0");
        // R6: decision lands as PWM rises
        period(100, 100, 100, 100, 0, 1, "R6 coincident rise");

        // Seeded random windows
        for (int i = 0; i < 80; i++) begin
            int s [4];
            temp_code = 8'($urandom_range(0, 255));
            for (int k = 0; k < 4; k++) begin
                s[k] = int'($urandom_range(200, 3800));
                if ($urandom_range(0, 40) == 0) s[k] = 4095;
            end
            period(s[0], s[1], s[2], s[3], bit'($urandom_range(0, 1)),
                   ($urandom_range(0, 9) == 0), "R2 R3 R4 R7 R9 random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule